// File: doc/BRIEF.md
# Command-Byte Register Access Decoder

This block sits behind a byte-level serial slave front end and turns the stream of received bytes into register accesses. Each write transaction opens with a command byte: it loads a 4-bit register pointer and may request a paired (word) transfer or a one-shot interrupt clear. Bytes that follow the command are written to the register under the pointer. Read requests from the front end return the byte under the pointer one cycle later.

The register map has sixteen 8-bit slots. They hold a power control field, a timing byte, two 16-bit threshold values, an interrupt control byte, a fixed identity byte and two live 16-bit result channels. The writable contents go out on ports to the neighbouring blocks. A read of a result low byte captures the matching high byte in a shadow register, so a low/high read pair always returns halves of the same sample.

Top module: `cmd_access_dec`

## Requirements
- R1: The first byte received after `txn_start` is a command when bit 7 is 1. Its bits 3:0 load the pointer, bit 5 is the word flag, bit 6 is the interrupt clear and bit 4 is ignored. If bit 7 of that first byte is 0, the byte is dropped and the pointer keeps its value.
- R2: A received byte that is not the first of its transaction is written to the register under the pointer. Slot 0 is power control, 1 is timing, 2/3 are the low/high bytes of `thr_lo`, 4/5 are the low/high bytes of `thr_hi` and 6 is interrupt control. The written value shows on the output ports the cycle after the byte.
- R3: Only bits 1:0 of slot 0 are stored. A read of slot 0 returns zero in bits 7:2.
- R4: A command with bit 6 set raises `int_clr` for exactly one cycle, the cycle after the command byte. The bit is not stored in any register.
- R5: With the word flag set, the pointer advances by one after the first data byte or read of the access and then stays. Without it, the pointer does not move.
- R6: A `rd_req` pulse produces `rd_valid` and `rd_data` for the pointed slot in the next cycle.
- R7: Slot 10 (Ah) reads as the `ID_VALUE` parameter. Writes to it are ignored.
- R8: Slots 7, 8, 9 and 11 read as 00h. Writes to them, and to the result slots 12 to 15, change nothing.
- R9: Slot 12 reads `ch0_data[7:0]` and captures `ch0_data[15:8]`. Slot 13 returns that captured byte even if `ch0_data` has changed since. Slots 14 and 15 do the same for `ch1_data`.
- R10: After reset, all stored registers, both shadows, the pointer, `int_clr`, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Pulse marking the start of a write transaction; exclusive with the byte strobes |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for one read byte; never together with rx_valid |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| ch0_data | input | 16 | Live result of channel 0 |
| ch1_data | input | 16 | Live result of channel 1 |
| pwr_ctrl | output | 2 | Stored power control field |
| timing_q | output | 8 | Timing register |
| thr_lo | output | 16 | Lower threshold |
| thr_hi | output | 16 | Upper threshold |
| intr_ctrl | output | 8 | Interrupt control register |
| int_clr | output | 1 | One-cycle interrupt clear pulse |

## Verification
Every result in this block lands one clock edge after its input strobe. That covers register outputs after a data byte, `int_clr` after a command and `rd_data` after `rd_req`. The bench drives strobes on falling edges and reads outputs in the low phase that follows the next rising edge. Read results go through a queue: the driver pushes the expected byte when it raises `rd_req`, and a monitor compares the next `rd_valid` byte shortly after the rising edge. The shadow and word cases change `ch0_data`/`ch1_data` between the paired reads. This shows that the returned high byte comes from the capture and not from the live input.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int CMD_BIT  = 7;
  localparam int CLR_BIT  = 6;
  localparam int WORD_BIT = 5;
  localparam int NUM_THR  = 4;
  localparam int NUM_CH   = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_PWR    = 4'h0;
  localparam addr_t A_TIMING = 4'h1;
  localparam addr_t A_THR0   = 4'h2;
  localparam addr_t A_INTR   = 4'h6;
  localparam addr_t A_ID     = 4'hA;
  localparam addr_t A_CH0    = 4'hC;
endpackage

// File: rtl/cad_ptr_ctl.sv
module cad_ptr_ctl
  import cad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rd_req,
  output addr_t             ptr,
  output logic              wr_en,
  output logic              expect_cmd,
  output logic              int_clr
);
  logic word_q, stepped_q;

  assign wr_en = rx_valid && !expect_cmd && !txn_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      word_q     <= 1'b0;
      stepped_q  <= 1'b0;
      expect_cmd <= 1'b0;
      int_clr    <= 1'b0;
    end else begin
      int_clr <= 1'b0;
      if (txn_start) begin
        expect_cmd <= 1'b1;
      end else if (rx_valid && expect_cmd) begin
        expect_cmd <= 1'b0;
        if (rx_data[CMD_BIT]) begin
          ptr       <= rx_data[ADDR_W-1:0];
          word_q    <= rx_data[WORD_BIT];
          stepped_q <= 1'b0;
          int_clr   <= rx_data[CLR_BIT];
        end
      end else if ((rx_valid || rd_req) && word_q && !stepped_q) begin
        ptr       <= ptr + addr_t'(1);
        stepped_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cad_regs.sv
module cad_regs
  import cad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  addr_t             wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [1:0]        pwr_ctrl,
  output logic [BYTE_W-1:0] timing_q,
  output logic [BYTE_W-1:0] thr_b [NUM_THR],
  output logic [BYTE_W-1:0] intr_ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_ctrl  <= '0;
      timing_q  <= '0;
      intr_ctrl <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PWR)    pwr_ctrl  <= wr_data[1:0];
      if (wr_addr == A_TIMING) timing_q  <= wr_data;
      if (wr_addr == A_INTR)   intr_ctrl <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    localparam addr_t SLOT = A_THR0 + addr_t'(i);
    always_ff @(posedge clk) begin
      if (rst)                             thr_b[i] <= '0;
      else if (wr_en && wr_addr == SLOT)   thr_b[i] <= wr_data;
    end
  end
endmodule

// File: rtl/cad_rd_path.sv
module cad_rd_path
  import cad_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE = 8'h5C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  addr_t               rd_addr,
  input  logic [1:0]          pwr_ctrl,
  input  logic [BYTE_W-1:0]   timing_q,
  input  logic [BYTE_W-1:0]   thr_b [NUM_THR],
  input  logic [BYTE_W-1:0]   intr_ctrl,
  input  logic [2*BYTE_W-1:0] ch_data [NUM_CH],
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data
);
  logic [BYTE_W-1:0] shadow [NUM_CH];
  logic [BYTE_W-1:0] mux;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sh
    localparam addr_t LO = A_CH0 + addr_t'(2*k);
    always_ff @(posedge clk) begin
      if (rst)                          shadow[k] <= '0;
      else if (rd_en && rd_addr == LO)  shadow[k] <= ch_data[k][2*BYTE_W-1:BYTE_W];
    end
  end

  always_comb begin
    mux = '0;
    if (rd_addr == A_PWR)    mux = {{(BYTE_W-2){1'b0}}, pwr_ctrl};
    if (rd_addr == A_TIMING) mux = timing_q;
    if (rd_addr == A_INTR)   mux = intr_ctrl;
    if (rd_addr == A_ID)     mux = ID_VALUE;
    for (int i = 0; i < NUM_THR; i++)
      if (rd_addr == A_THR0 + addr_t'(i)) mux = thr_b[i];
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_addr == A_CH0 + addr_t'(2*k))     mux = ch_data[k][BYTE_W-1:0];
      if (rd_addr == A_CH0 + addr_t'(2*k + 1)) mux = shadow[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux;
    end
  end
endmodule

// File: rtl/cmd_access_dec.sv
module cmd_access_dec
  import cad_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h5C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        txn_start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rd_req,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  input  logic [15:0] ch0_data,
  input  logic [15:0] ch1_data,
  output logic [1:0]  pwr_ctrl,
  output logic [7:0]  timing_q,
  output logic [15:0] thr_lo,
  output logic [15:0] thr_hi,
  output logic [7:0]  intr_ctrl,
  output logic        int_clr
);
  addr_t             ptr;
  logic              wr_en, expect_cmd;
  logic [BYTE_W-1:0] thr_b [NUM_THR];
  logic [2*BYTE_W-1:0] ch_data [NUM_CH];

  assign ch_data[0] = ch0_data;
  assign ch_data[1] = ch1_data;
  assign thr_lo = {thr_b[1], thr_b[0]};
  assign thr_hi = {thr_b[3], thr_b[2]};

  cad_ptr_ctl u_ptr (
    .clk(clk), .rst(rst), .txn_start(txn_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rd_req(rd_req), .ptr(ptr), .wr_en(wr_en),
    .expect_cmd(expect_cmd), .int_clr(int_clr)
  );

  cad_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_data),
    .pwr_ctrl(pwr_ctrl), .timing_q(timing_q), .thr_b(thr_b),
    .intr_ctrl(intr_ctrl)
  );

  cad_rd_path #(.ID_VALUE(ID_VALUE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_req), .rd_addr(ptr),
    .pwr_ctrl(pwr_ctrl), .timing_q(timing_q), .thr_b(thr_b),
    .intr_ctrl(intr_ctrl), .ch_data(ch_data), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/cad_chk.sv
module cad_chk #(
  parameter logic [7:0] ID_VALUE = 8'h5C
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rd_req,
  input logic [3:0]  ptr,
  input logic        expect_cmd,
  input logic        int_clr,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic [15:0] thr_lo,
  input logic [15:0] thr_hi
);
  p_cmd_load_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && expect_cmd && rx_data[7]) |=> (ptr == $past(rx_data[3:0])));

  p_thr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(thr_lo) && $stable(thr_hi)));

  p_pwr_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ptr == 4'h0) |=> (rd_data[7:2] == 6'd0));

  p_clr_src_r4: assert property (@(posedge clk) disable iff (rst)
    int_clr |-> $past(rx_valid && expect_cmd && rx_data[7] && rx_data[6]));

  p_clr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    int_clr |=> !int_clr);

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  p_rd_src_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  p_id_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ptr == 4'hA) |=> (rd_data == ID_VALUE));

  p_resv_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (ptr == 4'h7 || ptr == 4'h8 || ptr == 4'h9 || ptr == 4'hB))
      |=> (rd_data == 8'h00));
endmodule

bind cmd_access_dec cad_chk #(.ID_VALUE(ID_VALUE)) u_cad_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
  .rd_req(rd_req), .ptr(ptr), .expect_cmd(expect_cmd), .int_clr(int_clr),
  .rd_valid(rd_valid), .rd_data(rd_data), .thr_lo(thr_lo), .thr_hi(thr_hi)
);

// File: tb/tb_cmd_access_dec.sv
module tb_cmd_access_dec;
  localparam int CLK_P = 10;
  localparam logic [7:0] ID_V = 8'h5C;

  logic clk = 1'b0, rst = 1'b1;
  logic txn_start = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_data = '0;
  logic [15:0] ch0_data = '0, ch1_data = '0;
  logic rd_valid, int_clr;
  logic [7:0] rd_data, timing_q, intr_ctrl;
  logic [1:0] pwr_ctrl;
  logic [15:0] thr_lo, thr_hi;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  cmd_access_dec #(.ID_VALUE(ID_V)) dut (
    .clk(clk), .rst(rst), .txn_start(txn_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .ch0_data(ch0_data), .ch1_data(ch1_data),
    .pwr_ctrl(pwr_ctrl), .timing_q(timing_q), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .intr_ctrl(intr_ctrl), .int_clr(int_clr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_txn();
    @(negedge clk) txn_start = 1'b1;
    @(negedge clk) txn_start = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic cmd(logic [7:0] c);
    start_txn();
    send(c);
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    @(negedge clk) begin
      rd_req = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk) rd_req = 1'b0;
  endtask

  // scoreboard monitor: results sampled shortly after the rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_P * 100000);
    check("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 pwr reset", pwr_ctrl, 0);
    check("R10 thr reset", {thr_hi, thr_lo}, 0);
    check("R10 int_clr/rd_valid reset", {int_clr, rd_valid, rd_data}, 0);
    rd(8'h00, "R10 pointer reset reads slot0");

    send(8'h8A);                            // no txn_start: data to slot 0
    check("R3 pwr only two bits", pwr_ctrl, 2'b10);
    cmd(8'h80); send(8'hFF);
    check("R2 pwr write", pwr_ctrl, 2'b11);
    rd(8'h03, "R3 slot0 upper bits zero");

    cmd(8'hA2); send(8'h34); send(8'h12);
    check("R5 word write thr_lo", thr_lo, 16'h1234);
    cmd(8'h84); send(8'h11); send(8'h22);
    check("R5 no-word pointer stays", thr_hi, 16'h0022);
    cmd(8'h81); send(8'h5A);
    check("R2 timing write", timing_q, 8'h5A);
    cmd(8'h86); send(8'hC3);
    check("R2 intr write", intr_ctrl, 8'hC3);

    start_txn();
    @(negedge clk) begin rx_valid = 1'b1; rx_data = 8'hC0; end
    @(negedge clk) rx_valid = 1'b0;
    check("R4 int_clr pulse high", int_clr, 1);
    @(negedge clk);
    check("R4 int_clr one cycle", int_clr, 0);
    rd(8'h03, "R4 clear bit not stored");

    cmd(8'h86);
    start_txn(); send(8'h05);               // non-command first byte dropped
    check("R1 dropped byte no write", intr_ctrl, 8'hC3);
    rd(8'hC3, "R1 pointer kept after dropped byte");
    cmd(8'h91);
    rd(8'h5A, "R1 bit4 ignored");

    cmd(8'h8A); send(8'h99);
    rd(ID_V, "R7 id read after write");
    cmd(8'h87); send(8'hFF);
    rd(8'h00, "R8 slot7 reads zero");
    cmd(8'h8B);
    rd(8'h00, "R8 slot11 reads zero");
    check("R8 writes leave outputs", {pwr_ctrl, timing_q, intr_ctrl}, {2'b11, 8'h5A, 8'hC3});

    ch0_data = 16'h1234;
    cmd(8'h8C); send(8'hAA);
    rd(8'h34, "R8 slot12 write ignored");
    cmd(8'hAC);
    rd(8'h34, "R9 ch0 low");
    ch0_data = 16'hABCD;
    rd(8'h12, "R9 ch0 high from shadow");
    cmd(8'h8D);
    rd(8'h12, "R9 shadow held");
    ch1_data = 16'hBEEF;
    cmd(8'hAE);
    rd(8'hEF, "R9 ch1 low");
    ch1_data = 16'h0101;
    rd(8'hBE, "R9 ch1 high from shadow");

    cmd(8'hA2);
    rd(8'h34, "R6 word read low");
    rd(8'h12, "R5 word read high");
    rd(8'h12, "R5 pointer stops after one step");

    repeat (3) @(negedge clk);
    check("R6 all reads returned", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule